// File: doc/BRIEF.md
# Fiber Far-End Fault Manager

This block manages far-end fault handling for one 100 Mb/s fiber port. It takes the optical transceiver's signal-detect line, which arrives asynchronously, and a "remote fault pattern received" flag from the receive decoder. The two fault sources are merged into one sticky status bit. Software reads that bit through a read strobe, and the read clears it.

The block also owns the port's link state. The link comes up only after a run of clean idle symbols with no fault present. A far-end fault pattern seen before any idle keeps the link down. Any fault drops the link unless the forced-pass control is set. Each up-to-down change of the link raises a one-cycle interrupt pulse.

On the transmit side, the block asks the transmit encoder to send the far-end fault code while the local signal is lost and the code-transmit enable is set. Generating and detecting the pattern itself is handled elsewhere.

Top module: `fefault_mgr`

## Requirements
- R1: `sd_async` is active high (1 = optical signal present) and passes through a two-flop synchronizer. A change on it that is set up before clock edge k reaches `fault_sticky`, `link_up` and `tx_fault_req` at edge k+2.
- R2: `fault_sticky` goes to 1 at the edge that follows any cycle in which a fault is present. A fault is present when the synchronized signal-detect is 0, or when `rx_rfault` is 1, or both.
- R3: Once set, `fault_sticky` stays at 1 until a cycle with `stat_rd` = 1. At the following edge it clears, unless a fault is present in that read cycle, in which case it stays at 1.
- R4: While the link is down and `force_pass` is 0, the link comes up only at the edge that ends IDLE_RUN (default 4) consecutive cycles in which `rx_idle` = 1 and no fault is present. A cycle without idle, or with a fault, restarts the run. If a remote fault pattern is seen first, the link stays down.
- R5: While the link is up and `force_pass` is 0, a fault present in a cycle brings `link_up` to 0 at the next edge.
- R6: With `force_pass` = 1, `link_up` is 1 from the next edge onward, and no fault brings it down.
- R7: `link_down_irq` is 1 for exactly one cycle: the first cycle in which `link_up` reads 0 after having been 1.
- R8: `tx_fault_req` is 1 from the edge that follows a cycle in which `fault_tx_en` = 1 and the synchronized signal-detect is 0. In every other case it is 0.
- R9: While `rst` is high, all outputs are 0 from the first edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_async | input | 1 | Transceiver signal detect, asynchronous, 1 = signal present |
| rx_rfault | input | 1 | Receive path reports the far-end fault pattern |
| rx_idle | input | 1 | Receive path reports idle symbols |
| force_pass | input | 1 | Forced link pass: faults never drop the link |
| fault_tx_en | input | 1 | Enable for requesting the far-end fault code |
| stat_rd | input | 1 | Read strobe for the sticky fault bit (clears it) |
| link_up | output | 1 | Link status |
| fault_sticky | output | 1 | Latched fault status, cleared by a read |
| link_down_irq | output | 1 | One-cycle pulse when the link is lost |
| tx_fault_req | output | 1 | Request to transmit the far-end fault code |

## Verification
Inputs change half a cycle before a rising edge, and outputs are sampled half a cycle after one. This makes the due times exact. Results that depend on `rx_rfault`, `stat_rd` or `force_pass` are due one edge after the stimulus. Results that depend on `sd_async` are due on the third edge, and the bench checks the value at the second edge as well so that an early response is caught. Link bring-up is checked one edge before and at the edge where the idle run completes. The interrupt is checked both in its cycle and in the cycle after. A sweep over all sixteen combinations of the four static inputs checks the settled link, request and sticky-bit values against formulas computed in the bench.

// File: rtl/ffm_pkg.sv
package ffm_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_st_t;

    typedef struct packed {
        logic local_loss;
        logic remote_flag;
    } fault_src_t;

    function automatic logic any_fault(input fault_src_t s);
        return s.local_loss | s.remote_flag;
    endfunction

    function automatic logic idle_ok(input logic idle, input fault_src_t s);
        return idle & ~any_fault(s);
    endfunction

endpackage

// File: rtl/ffm_sync.sv
module ffm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

    a_r1_sync_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(chain[0]) |=> chain[1]);

endmodule

// File: rtl/ffm_fault_latch.sv
module ffm_fault_latch
    import ffm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_src_t src,
    input  logic       rd,
    output logic       sticky
);
    logic fault_now;
    logic sticky_q;

    assign fault_now = any_fault(src);

    always_ff @(posedge clk) begin
        if (rst) sticky_q <= 1'b0;
        else     sticky_q <= (sticky_q & ~rd) | fault_now;
    end

    assign sticky = sticky_q;

    a_r2_set_on_fault: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> sticky_q);

    a_r3_hold_until_read: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && !rd) |=> sticky_q);

    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd && !fault_now) |=> !sticky_q);

endmodule

// File: rtl/ffm_link_fsm.sv
module ffm_link_fsm
    import ffm_pkg::*;
#(
    parameter int IDLE_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  fault_src_t src,
    input  logic       rx_idle,
    input  logic       force_pass,
    output logic       link_up,
    output logic       down_irq
);
    localparam int CW = $clog2(IDLE_RUN + 1);
    localparam logic [CW-1:0] RUN_L = CW'(IDLE_RUN);

    link_st_t   st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic       qual;
    logic       fault_now;
    logic       irq_q;

    assign fault_now = any_fault(src);
    assign qual      = idle_ok(rx_idle, src);

    always_comb begin
        if (!qual)              cnt_n = '0;
        else if (cnt_q == RUN_L) cnt_n = cnt_q;
        else                    cnt_n = cnt_q + 1'b1;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            LNK_DOWN: if (force_pass || cnt_n == RUN_L) st_n = LNK_UP;
            LNK_UP:   if (fault_now && !force_pass)     st_n = LNK_DOWN;
            default:  st_n = LNK_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LNK_DOWN;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            irq_q <= (st_q == LNK_UP) && (st_n == LNK_DOWN);
        end
    end

    assign link_up  = (st_q == LNK_UP);
    assign down_irq = irq_q;

    a_r4_no_up_on_fault: assert property (@(posedge clk) disable iff (rst)
        (!link_up && fault_now && !force_pass) |=> !link_up);

    a_r4_no_up_without_idle: assert property (@(posedge clk) disable iff (rst)
        (!link_up && !rx_idle && !force_pass) |=> !link_up);

    a_r5_drop_on_fault: assert property (@(posedge clk) disable iff (rst)
        (link_up && fault_now && !force_pass) |=> !link_up);

    a_r6_force_holds: assert property (@(posedge clk) disable iff (rst)
        force_pass |=> link_up);

    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        down_irq |=> !down_irq);

    a_r7_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
        (link_up && fault_now && !force_pass) |=> down_irq);

endmodule

// File: rtl/fefault_mgr.sv
module fefault_mgr
    import ffm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_RUN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sd_async,
    input  logic rx_rfault,
    input  logic rx_idle,
    input  logic force_pass,
    input  logic fault_tx_en,
    input  logic stat_rd,
    output logic link_up,
    output logic fault_sticky,
    output logic link_down_irq,
    output logic tx_fault_req
);
    logic       sd_sync;
    fault_src_t src;
    logic       req_q;

    ffm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sd_async),
        .q_sync  (sd_sync)
    );

    assign src.local_loss  = ~sd_sync;
    assign src.remote_flag = rx_rfault;

    ffm_fault_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .rd     (stat_rd),
        .sticky (fault_sticky)
    );

    ffm_link_fsm #(.IDLE_RUN(IDLE_RUN)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .rx_idle    (rx_idle),
        .force_pass (force_pass),
        .link_up    (link_up),
        .down_irq   (link_down_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= fault_tx_en & src.local_loss;
    end

    assign tx_fault_req = req_q;

    a_r8_req_on_loss: assert property (@(posedge clk) disable iff (rst)
        (fault_tx_en && !sd_sync) |=> tx_fault_req);

    a_r8_no_req_disabled: assert property (@(posedge clk) disable iff (rst)
        !fault_tx_en |=> !tx_fault_req);

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!link_up && !link_down_irq && !tx_fault_req));

endmodule

// File: tb/fefault_mgr_bench.sv
`timescale 1ns/1ps
module fefault_mgr_bench;
    localparam int RUN = 4;

    logic clk = 1'b0;
    logic rst, sd, rf, idle, force_p, txen, rd;
    logic link_up, fault_sticky, irq, req;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2 clk = ~clk;

    fefault_mgr #(.SYNC_STAGES(2), .IDLE_RUN(RUN)) u_fefault_mgr (
        .clk(clk), .rst(rst), .sd_async(sd), .rx_rfault(rf), .rx_idle(idle),
        .force_pass(force_p), .fault_tx_en(txen), .stat_rd(rd),
        .link_up(link_up), .fault_sticky(fault_sticky),
        .link_down_irq(irq), .tx_fault_req(req)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; sd = 1; rf = 0; idle = 0; force_p = 0; txen = 0; rd = 0;
        @(negedge clk);
        tick(3);
        chk("R9 link", link_up, 0);
        chk("R9 sticky", fault_sticky, 0);
        chk("R9 irq", irq, 0);
        chk("R9 req", req, 0);

        rst = 0;
        tick(5);
        chk("R2 sticky after sync fill", fault_sticky, 1);
        rd = 1; tick(); rd = 0;
        chk("R3 read clears", fault_sticky, 0);

        idle = 1;
        tick(RUN - 1);
        chk("R4 early", link_up, 0);
        tick();
        chk("R4 up", link_up, 1);
        chk("R7 no irq on rise", irq, 0);

        rf = 1; idle = 0;
        tick();
        chk("R5 drop", link_up, 0);
        chk("R7 irq", irq, 1);
        chk("R2 remote sets", fault_sticky, 1);
        tick();
        chk("R7 irq one cycle", irq, 0);

        idle = 1;
        tick(6);
        chk("R4 remote first stays down", link_up, 0);
        rf = 0; tick(2); idle = 0; tick(); idle = 1;
        tick(RUN - 1);
        chk("R4 gap restarts", link_up, 0);
        tick();
        chk("R4 up after fresh run", link_up, 1);

        sd = 0; txen = 1;
        tick(2);
        chk("R1 not yet", link_up, 1);
        chk("R1 req not yet", req, 0);
        tick();
        chk("R1 sd drop", link_up, 0);
        chk("R8 req", req, 1);
        chk("R7 irq sd", irq, 1);

        rd = 1; tick(); rd = 0;
        chk("R3 read while fault", fault_sticky, 1);

        sd = 1;
        tick(3);
        chk("R8 req off", req, 0);
        rd = 1; tick(); rd = 0;
        chk("R3 clear after recovery", fault_sticky, 0);
        tick(RUN);
        chk("R4 return after recovery", link_up, 1);

        force_p = 1; rf = 1;
        tick();
        chk("R6 hold", link_up, 1);
        chk("R6 no irq", irq, 0);
        tick(5);
        chk("R6 hold long", link_up, 1);
        force_p = 0;
        tick();
        chk("R5 drop after force off", link_up, 0);
        chk("R7 irq after force off", irq, 1);
        force_p = 1; idle = 0;
        tick();
        chk("R6 forced up", link_up, 1);
        force_p = 0; rf = 0;

        for (int c = 0; c < 16; c++) begin
            logic f, t, s, r;
            {f, t, s, r} = c[3:0];
            rst = 1; force_p = f; txen = t; sd = s; rf = r; idle = 1; rd = 0;
            tick(2);
            rst = 0;
            tick(12);
            chk("R6 R4 sweep link", link_up, f | (s & ~r));
            chk("R8 sweep req", req, t & ~s);
            rd = 1; tick(); rd = 0;
            chk("R3 sweep sticky", fault_sticky, ~s | r);
            chk("R7 sweep irq", irq, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule